// File: doc/BRIEF.md
# Dual-format serial audio receiver

This block takes stereo PCM audio from a three-wire serial link (bit clock, frame clock, serial data) and turns each frame into a pair of parallel 24-bit samples in the system clock domain. A static format pin picks one of two framings. With the pin low, framing is left-justified: the most significant bit follows the frame-clock edge at once. With the pin high, framing is I2S: data lags the frame-clock edge by one bit period.

The serial clocks and data go through two-flop synchronisers. Bit-clock rising edges are detected in the system domain, and each bit is sampled there. Every half-frame collects up to 24 bits, MSB first. Bits past the 24th are discarded. The left word is held until the right word of the same frame completes. Both words are then placed on the outputs together with a single-cycle valid strobe. The bit clock must be several times slower than the system clock so that every bit-clock level is seen by the synchronisers.

Top module: `dual_fmt_pcm_rx`

## Requirements
- R1: While reset is asserted, and after it is released, valid_o is low and left_o and right_o are zero until the first frame completes.
- R2: With fmt_i low (left-justified), the bit sampled on the first bit-clock rise after a frame-clock change is the MSB (bit 23). The channel received while the frame clock is high is the left channel.
- R3: With fmt_i high (I2S), the MSB is sampled on the second bit-clock rise after a frame-clock change, one bit period later than in left-justified framing. The channel received while the frame clock is low is the left channel.
- R4: Each sample is a 24-bit two's-complement word, sent MSB first. It appears on the output bit for bit, including the full-scale values 24'h800000 and 24'h7FFFFF.
- R5: When a half-frame carries 32 bit periods, the bits after the 24th have no effect on the output word.
- R6: Frames of 24 bit periods per half-frame (48 per frame) are received correctly in both formats. This includes I2S, where the right-channel LSB falls in the first bit period after the frame-clock edge.
- R7: valid_o is high for exactly one system clock cycle, a few cycles after the last bit of the right word. left_o and right_o change together only with that pulse and hold their values otherwise.
- R8: If a half-frame ends with fewer than 24 bit periods, no valid pulse is produced for that frame and the outputs keep their previous values. A new left half-frame discards any left word still waiting.
- R9: Back-to-back frames produce one valid pulse each, carrying the words of those frames in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock (asynchronous to clk) |
| fclk_i | input | 1 | Frame (left/right) clock |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 1 | Framing select: 0 left-justified, 1 I2S |
| left_o | output | SAMPLE_W | Left-channel sample, two's complement |
| right_o | output | SAMPLE_W | Right-channel sample, two's complement |
| valid_o | output | 1 | One-cycle strobe marking new left_o/right_o |

## Verification
A vector table drives single frames in both framings, at 48, 56 and 64 bit periods per frame. The words include full-scale negative and positive values, alternating patterns, a lone LSB, and 16-bit zero-filled data. These vectors separate a wrong one-bit delay, swapped channel polarity, a shifted or mis-ordered bit, and extra trailing bits leaking into the word. Directed runs send an all-zero I2S frame with ones in the trailing bit slots, which shows whether those slots are really ignored. Another run truncates the right half-frame and checks that no valid appears and the outputs hold. A continuous three-frame stream checks pulse count, ordering and single-cycle strobe width.

// File: rtl/pcmrx_pkg.sv
package pcmrx_pkg;

    // One sampled bit-clock event, as seen in the system clock domain
    typedef struct packed {
        logic stb;       // a bit-clock rise was seen
        logic bitv;      // serial data at that rise
        logic edge_hit;  // first data bit of a new half-frame
        logic left;      // half-frame belongs to the left channel
    } pcmrx_ev_t;

endpackage

// File: rtl/pcmrx_sync.sv
module pcmrx_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.s2;

endmodule

// File: rtl/pcmrx_framer.sv
module pcmrx_framer
    import pcmrx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bclk_s,
    input  logic      ws_s,
    input  logic      sd_s,
    input  logic      fmt_i,
    output pcmrx_ev_t ev_o
);

    typedef struct packed {
        logic       bclk;   // bit clock level at previous system cycle
        logic       ws1;    // frame clock at the last bit-clock rise
        logic       ws2;    // frame clock one rise earlier
        logic [1:0] prime;  // rises seen since reset, saturating at 2
        pcmrx_ev_t  ev;
    } frm_st_t;

    frm_st_t st_d, st_q;

    logic rise;
    logic eff_new;
    logic eff_old;

    always_comb begin
        st_d      = st_q;
        st_d.ev   = '0;
        st_d.bclk = bclk_s;
        rise      = bclk_s & ~st_q.bclk;
        // I2S: data lags the frame clock by one bit, so frame on the delayed copy
        eff_new   = fmt_i ? st_q.ws1 : ws_s;
        eff_old   = fmt_i ? st_q.ws2 : st_q.ws1;
        if (rise) begin
            st_d.ev.stb      = 1'b1;
            st_d.ev.bitv     = sd_s;
            st_d.ev.edge_hit = (eff_new != eff_old) && (st_q.prime == 2'd2);
            st_d.ev.left     = fmt_i ? ~eff_new : eff_new;
            st_d.ws2         = st_q.ws1;
            st_d.ws1         = ws_s;
            if (st_q.prime != 2'd2) st_d.prime = st_q.prime + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ev_o = st_q.ev;

endmodule

// File: rtl/pcmrx_deser.sv
module pcmrx_deser
    import pcmrx_pkg::*;
#(
    parameter int   W       = 24,
    parameter logic IS_LEFT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  pcmrx_ev_t    ev_i,
    output logic [W-1:0] word_o,
    output logic         done_o
);

    localparam int            CW   = $clog2(W + 1);
    localparam logic [CW-1:0] FULL = CW'(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic [W-1:0]  word;
        logic [CW-1:0] cnt;   // bits stored in this half-frame; FULL = idle
        logic          done;
    } des_st_t;

    des_st_t st_d, st_q;
    logic    mine;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        mine      = ev_i.stb && (ev_i.left == IS_LEFT);
        if (mine && ev_i.edge_hit) begin
            st_d.word        = '0;
            st_d.word[W-1]   = ev_i.bitv;
            st_d.cnt         = CW'(1);
            st_d.done        = (W == 1);
        end else if (mine && (st_q.cnt < FULL)) begin
            for (int i = 0; i < W; i++) begin
                if (CW'(W - 1 - i) == st_q.cnt) st_d.word[i] = ev_i.bitv;
            end
            st_d.cnt  = st_q.cnt + CW'(1);
            st_d.done = (st_q.cnt == LAST);
        end else if (ev_i.stb && ev_i.edge_hit && !mine) begin
            // other channel started: an unfinished word here is abandoned
            st_d.cnt = FULL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cnt <= FULL;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.word;
    assign done_o = st_q.done;

endmodule

// File: rtl/dual_fmt_pcm_rx.sv
module dual_fmt_pcm_rx
    import pcmrx_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_i,
    input  logic                fclk_i,
    input  logic                sdata_i,
    input  logic                fmt_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);

    localparam int NSYNC = 3;

    logic [NSYNC-1:0] raw_in;
    logic [NSYNC-1:0] syn_in;
    pcmrx_ev_t        ev;

    logic [SAMPLE_W-1:0] ch_word [2];
    logic [1:0]          ch_done;
    logic [SAMPLE_W-1:0] l_word, r_word;
    logic                l_done, r_done;

    assign raw_in = {bclk_i, fclk_i, sdata_i};

    pcmrx_sync #(.W(NSYNC)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn_in)
    );

    pcmrx_framer framer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .bclk_s (syn_in[2]),
        .ws_s   (syn_in[1]),
        .sd_s   (syn_in[0]),
        .fmt_i  (fmt_i),
        .ev_o   (ev)
    );

    // index 0 = right, index 1 = left
    for (genvar c = 0; c < 2; c++) begin : g_ch
        pcmrx_deser #(
            .W       (SAMPLE_W),
            .IS_LEFT (1'(c))
        ) deser_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .ev_i   (ev),
            .word_o (ch_word[c]),
            .done_o (ch_done[c])
        );
    end

    assign l_word = ch_word[1];
    assign r_word = ch_word[0];
    assign l_done = ch_done[1];
    assign r_done = ch_done[0];

    typedef struct packed {
        logic [SAMPLE_W-1:0] lhold;
        logic                lok;
        logic [SAMPLE_W-1:0] outl;
        logic [SAMPLE_W-1:0] outr;
        logic                vld;
    } top_st_t;

    top_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (ev.stb && ev.edge_hit && ev.left) st_d.lok = 1'b0;
        if (l_done) begin
            st_d.lhold = l_word;
            st_d.lok   = 1'b1;
        end
        if (r_done && st_q.lok) begin
            st_d.outl = st_q.lhold;
            st_d.outr = r_word;
            st_d.vld  = 1'b1;
            st_d.lok  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign left_o  = st_q.outl;
    assign right_o = st_q.outr;
    assign valid_o = st_q.vld;

endmodule

// File: rtl/pcmrx_chk.sv
module pcmrx_chk #(
    parameter int W = 24
) (
    input logic         clk,
    input logic         rst_n,
    input logic         valid_o,
    input logic [W-1:0] left_o,
    input logic [W-1:0] right_o,
    input logic         l_done,
    input logic         r_done
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && left_o == '0 && right_o == '0)); // R1

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R7

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(left_o) && $stable(right_o))); // R7

    AST_VALID_AFTER_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(r_done)); // R7

    AST_ONE_CHANNEL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_done && r_done)); // R9

endmodule

bind dual_fmt_pcm_rx pcmrx_chk #(.W(SAMPLE_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_o (valid_o),
    .left_o  (left_o),
    .right_o (right_o),
    .l_done  (l_done),
    .r_done  (r_done)
);

// File: tb/dual_fmt_pcm_rx_tb_top.sv
module dual_fmt_pcm_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n, bclk, fclk, sdata, fmt;
    logic [23:0] left_o, right_o;
    logic        valid_o;

    always #4 clk = ~clk;

    dual_fmt_pcm_rx dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .bclk_i  (bclk),
        .fclk_i  (fclk),
        .sdata_i (sdata),
        .fmt_i   (fmt),
        .left_o  (left_o),
        .right_o (right_o),
        .valid_o (valid_o)
    );

    int total = 0;
    int bad   = 0;

    // stream of bit periods: channel level (data-aligned) and data bit
    logic s_ws [0:1023];
    logic s_sd [0:1023];
    int   s_len = 0;

    logic [23:0] cap_l [0:7];
    logic [23:0] cap_r [0:7];
    int          cap_n = 0;
    int          wide_err = 0;
    logic        prev_v = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (valid_o) begin
                if (cap_n < 8) begin
                    cap_l[cap_n] = left_o;
                    cap_r[cap_n] = right_o;
                end
                cap_n++;
                if (prev_v) wide_err++;
            end
            prev_v = valid_o;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // channel level: left-justified left=1, I2S left=0
    task automatic add_half(input logic is_left, input logic [23:0] w, input int nb, input logic f);
        for (int i = 0; i < nb; i++) begin
            s_ws[s_len] = f ? ~is_left : is_left;
            s_sd[s_len] = (i < 24) ? w[23-i] : ~i[0];
            s_len++;
        end
    endtask

    task automatic play(input logic f);
        fmt = f;
        for (int t = 0; t < s_len; t++) begin
            // I2S frame clock leads the data by one bit period
            fclk  = (f && (t + 1 < s_len)) ? s_ws[t+1] : s_ws[t];
            sdata = s_sd[t];
            #40 bclk = 1'b1;
            #40 bclk = 1'b0;
        end
        s_len = 0;
        repeat (30) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_vec(input logic f, input int nb, input logic [23:0] lw, input logic [23:0] rw, input string tag);
        cap_n = 0;
        add_half(1'b0, 24'h5A5A5A, nb, f);
        add_half(1'b1, lw, nb, f);
        add_half(1'b0, rw, nb, f);
        add_half(1'b1, 24'h0F0F0F, 4, f);
        play(f);
        chk(cap_n == 1, tag, 48'(cap_n), 48'd1);
        chk({cap_l[0], cap_r[0]} == {lw, rw}, tag, {cap_l[0], cap_r[0]}, {lw, rw});
        chk({left_o, right_o} == {lw, rw}, "R7", {left_o, right_o}, {lw, rw});
    endtask

    // {fmt, bit periods per half-frame, left, right}
    localparam logic [54:0] VEC [0:7] = '{
        {1'b0, 6'd32, 24'h800000, 24'h7FFFFF},
        {1'b0, 6'd24, 24'h123456, 24'hFEDCBA},
        {1'b1, 6'd32, 24'hA5A5A5, 24'h5A5A5A},
        {1'b1, 6'd24, 24'h000001, 24'h800001},
        {1'b0, 6'd32, 24'hABCD00, 24'h123400},
        {1'b1, 6'd32, 24'hFFFFFF, 24'h000000},
        {1'b0, 6'd28, 24'hC0FFEE, 24'h0BEEF1},
        {1'b1, 6'd28, 24'h7FFFFF, 24'h800000}
    };

    initial begin
        #1ms;
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [47:0] held;
        rst_n = 1'b0; bclk = 1'b0; fclk = 1'b0; sdata = 1'b0; fmt = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(!valid_o && left_o == 0 && right_o == 0, "R1", {left_o, right_o}, 48'd0); // R1
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(!valid_o && left_o == 0 && right_o == 0, "R1", {left_o, right_o}, 48'd0); // R1

        // table: R2 (LJ), R3 (I2S), R6 (48 per frame), R5 (trailing bits)
        for (int v = 0; v < 8; v++) begin
            int nb;
            nb = int'(VEC[v][53:48]);
            run_vec(VEC[v][54], nb, VEC[v][47:24], VEC[v][23:0],
                    (nb == 24) ? "R6" : (VEC[v][54] ? "R3" : "R2"));
        end

        // R4: full-scale two's complement in both framings
        run_vec(1'b0, 32, 24'h800000, 24'h7FFFFF, "R4");
        run_vec(1'b1, 24, 24'h7FFFFF, 24'h800000, "R4");

        // R5: zero words, trailing slots carry ones
        run_vec(1'b1, 32, 24'h000000, 24'h000000, "R5");
        run_vec(1'b0, 32, 24'h000000, 24'h000000, "R5");

        // R8: truncated right half-frame gives no strobe, outputs hold
        held  = {left_o, right_o};
        cap_n = 0;
        add_half(1'b0, 24'h5A5A5A, 32, 1'b1);
        add_half(1'b1, 24'h111111, 32, 1'b1);
        add_half(1'b0, 24'h222222, 20, 1'b1);
        add_half(1'b1, 24'h333333, 4, 1'b1);
        play(1'b1);
        chk(cap_n == 0, "R8", 48'(cap_n), 48'd0);
        chk({left_o, right_o} == held, "R8", {left_o, right_o}, held);

        // R9: three back-to-back frames
        cap_n = 0;
        add_half(1'b0, 24'h5A5A5A, 32, 1'b0);
        add_half(1'b1, 24'h010203, 32, 1'b0);
        add_half(1'b0, 24'h040506, 32, 1'b0);
        add_half(1'b1, 24'h070809, 32, 1'b0);
        add_half(1'b0, 24'h0A0B0C, 32, 1'b0);
        add_half(1'b1, 24'hF00D01, 32, 1'b0);
        add_half(1'b0, 24'hF00D02, 32, 1'b0);
        add_half(1'b1, 24'h0F0F0F, 4, 1'b0);
        play(1'b0);
        chk(cap_n == 3, "R9", 48'(cap_n), 48'd3);
        chk({cap_l[0], cap_r[0]} == {24'h010203, 24'h040506}, "R9", {cap_l[0], cap_r[0]}, {24'h010203, 24'h040506});
        chk({cap_l[1], cap_r[1]} == {24'h070809, 24'h0A0B0C}, "R9", {cap_l[1], cap_r[1]}, {24'h070809, 24'h0A0B0C});
        chk({cap_l[2], cap_r[2]} == {24'hF00D01, 24'hF00D02}, "R9", {cap_l[2], cap_r[2]}, {24'hF00D01, 24'hF00D02});

        // R7: every strobe was a single cycle
        chk(wide_err == 0, "R7", 48'(wide_err), 48'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule